// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block collects every interrupt condition of one UART channel, masks each interrupt type with its own enable bit and reports the most urgent pending condition as a 6-bit identification code. An active-low request line tells the host that at least one enabled condition is pending. The host reads the identification code to learn which service routine to run, and some reads also acknowledge the condition that was reported.

Two kinds of source exist. Level sources follow their input as it is: the receiver error summary flag, the receive time-out and the receive-data-ready condition. Event sources are one-cycle pulses, or edges on the flow-control pins, held in a latch until their own clear condition occurs. The flow-control character source holds two latches. A stop-character latch is released only by a start-character detect. A special-character latch is released by an identification read that reports it.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq_n_o` is 1 and `ident_o` is 6'b000001, and all event latches are empty.
- R2: `irq_n_o` is 0 exactly when at least one enabled source is pending. `ident_o[0]` equals `irq_n_o`.
- R3: When it is the only pending source, each source reports its own code. Line errors give 000110. RX time-out gives 001100. RX data ready gives 000100. TX empty or trigger gives 000010. Modem change gives 000000. I/O pin change gives 001110. Stop character or special character gives 010000. CTS/RTS deassertion gives 100000.
- R4: Priority runs in the order listed in R3, from first to last. RX time-out wins over RX data ready.
- R5: The enable bits map as follows. `en_i[0]` is line errors, `[1]` is RX time-out and RX data, `[2]` is TX, `[3]` is modem, `[4]` is I/O pins, `[5]` is stop/special character and `[6]` is CTS/RTS. A disabled source does not assert `irq_n_o` and is not reported. Its event latch still records the event, and the event is reported once the source is enabled.
- R6: A stop-character detect is held until a start-character detect (`xon_det_i`). An identification read does not clear it.
- R7: A special-character detect is held until an identification read that returns 010000.
- R8: The CTS/RTS source fires only when `cts_n_i` or `rts_n_i` goes from 0 to 1. A 1-to-0 transition has no effect.
- R9: The TX event is held until an identification read that returns 000010. A read that returns any other code leaves it set.
- R10: A modem-status read strobe (`msr_rd_i`) clears both the modem-change latch and the CTS/RTS latch. An identification read clears neither.
- R11: The I/O pin change event is held until an identification read that returns 001110.
- R12: Level sources act in the same cycle their input changes, with no latching. Event latches take effect one clock after the pulse. A new event wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 7 | Per-type interrupt enables (see R5) |
| lsr_err_i | input | 1 | Level: some error exists anywhere in the RX FIFO |
| rx_tout_i | input | 1 | Level: RX FIFO data went stale |
| rx_rdy_i | input | 1 | Level: RX data ready or above trigger |
| tx_evt_i | input | 1 | Pulse: TX empty or trigger reached |
| modem_chg_i | input | 1 | Pulse: modem input changed |
| gpio_chg_i | input | 1 | Pulse: I/O input pin changed |
| xoff_det_i | input | 1 | Pulse: stop flow character received |
| spchar_det_i | input | 1 | Pulse: special character received |
| xon_det_i | input | 1 | Pulse: start flow character received |
| cts_n_i | input | 1 | CTS pin level, active low |
| rts_n_i | input | 1 | RTS pin level, active low |
| ident_rd_i | input | 1 | Strobe: host reads the identification code |
| msr_rd_i | input | 1 | Strobe: host reads modem status |
| irq_n_o | output | 1 | Interrupt request, active low |
| ident_o | output | 6 | Identification code of the highest pending source |

## Verification
The assertions assume that every input is synchronous to `clk` and free of X after reset. They also assume that read and detect strobes are single-cycle pulses, and that an identification read returns the `ident_o` value present in the cycle the strobe is high. The stimulus changes every input on the falling edge and pulses each strobe for exactly one cycle. It samples results one full cycle later, so each latch has taken its new value before the bench compares it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_TYPES = 7;
    localparam int NUM_SRC   = 8;
    localparam int ID_W      = 6;

    localparam logic [ID_W-1:0] ID_NONE   = 6'b000001;
    localparam logic [ID_W-1:0] ID_LINE   = 6'b000110;
    localparam logic [ID_W-1:0] ID_TOUT   = 6'b001100;
    localparam logic [ID_W-1:0] ID_RXD    = 6'b000100;
    localparam logic [ID_W-1:0] ID_TX     = 6'b000010;
    localparam logic [ID_W-1:0] ID_MODEM  = 6'b000000;
    localparam logic [ID_W-1:0] ID_GPIO   = 6'b001110;
    localparam logic [ID_W-1:0] ID_FLOW   = 6'b010000;
    localparam logic [ID_W-1:0] ID_PIN    = 6'b100000;

    // Source index order is the priority order (0 = most urgent).
    typedef enum logic [2:0] {
        SRC_LINE  = 3'd0,
        SRC_TOUT  = 3'd1,
        SRC_RXD   = 3'd2,
        SRC_TX    = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_GPIO  = 3'd5,
        SRC_FLOW  = 3'd6,
        SRC_PIN   = 3'd7
    } src_e;

    typedef struct packed {
        logic tx;
        logic modem;
        logic gpio;
        logic xoff;
        logic spc;
        logic pin;
        logic cts_prev;
        logic rts_prev;
    } evt_state_t;

    function automatic logic [ID_W-1:0] src_code(input int idx);
        case (idx)
            0:       return ID_LINE;
            1:       return ID_TOUT;
            2:       return ID_RXD;
            3:       return ID_TX;
            4:       return ID_MODEM;
            5:       return ID_GPIO;
            6:       return ID_FLOW;
            default: return ID_PIN;
        endcase
    endfunction

    // Enable bit that gates each source; the two receive-data sources share one.
    function automatic int src_type(input int idx);
        if (idx == 0) return 0;
        if (idx <= 2) return 1;
        return idx - 1;
    endfunction

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_evt_i,
    input  logic       modem_chg_i,
    input  logic       gpio_chg_i,
    input  logic       xoff_det_i,
    input  logic       spchar_det_i,
    input  logic       xon_det_i,
    input  logic       cts_n_i,
    input  logic       rts_n_i,
    input  logic       tx_clr_i,
    input  logic       gpio_clr_i,
    input  logic       spc_clr_i,
    input  logic       msr_rd_i,
    output logic       tx_o,
    output logic       modem_o,
    output logic       gpio_o,
    output logic       flow_o,
    output logic       pin_o
);

    evt_state_t st_d, st_q;
    logic       pin_rise;

    always_comb begin
        st_d     = st_q;
        pin_rise = (cts_n_i & ~st_q.cts_prev) | (rts_n_i & ~st_q.rts_prev);

        // a fresh event always beats a clear arriving in the same cycle
        st_d.tx       = tx_evt_i     | (st_q.tx    & ~tx_clr_i);
        st_d.modem    = modem_chg_i  | (st_q.modem & ~msr_rd_i);
        st_d.gpio     = gpio_chg_i   | (st_q.gpio  & ~gpio_clr_i);
        st_d.xoff     = xoff_det_i   | (st_q.xoff  & ~xon_det_i);
        st_d.spc      = spchar_det_i | (st_q.spc   & ~spc_clr_i);
        st_d.pin      = pin_rise     | (st_q.pin   & ~msr_rd_i);
        st_d.cts_prev = cts_n_i;
        st_d.rts_prev = rts_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cts_prev <= 1'b1;
            st_q.rts_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_o    = st_q.tx;
    assign modem_o = st_q.modem;
    assign gpio_o  = st_q.gpio;
    assign flow_o  = st_q.xoff | st_q.spc;
    assign pin_o   = st_q.pin;

    AST_XOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.xoff) && !$past(xon_det_i)) |-> st_q.xoff); // R6

    AST_SPC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spc_clr_i && !spchar_det_i) |-> !st_q.spc); // R7

    AST_PIN_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pin) |-> $past((cts_n_i && !st_q.cts_prev) || (rts_n_i && !st_q.rts_prev))); // R8

    AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(msr_rd_i && !modem_chg_i) |-> !st_q.modem); // R10

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int N_TYPE = NUM_TYPES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [N_TYPE-1:0] en_i,
    output logic              irq_n_o,
    output logic [ID_W-1:0]   ident_o
);

    logic [N_SRC-1:0] pend;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign pend[g] = src_i[g] & en_i[src_type(g)];
    end

    always_comb begin
        ident_o = ID_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) ident_o = src_code(i);
        end
        irq_n_o = ~|pend;
    end

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == ident_o[0]); // R2

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[SRC_LINE] && en_i[0]) |-> ident_o == ID_LINE); // R4

    AST_TOUT_OVER_RXD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[SRC_TOUT] && en_i[1] && !(src_i[SRC_LINE] && en_i[0])) |-> ident_o == ID_TOUT); // R4

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] en_i,
    input  logic       lsr_err_i,
    input  logic       rx_tout_i,
    input  logic       rx_rdy_i,
    input  logic       tx_evt_i,
    input  logic       modem_chg_i,
    input  logic       gpio_chg_i,
    input  logic       xoff_det_i,
    input  logic       spchar_det_i,
    input  logic       xon_det_i,
    input  logic       cts_n_i,
    input  logic       rts_n_i,
    input  logic       ident_rd_i,
    input  logic       msr_rd_i,
    output logic       irq_n_o,
    output logic [5:0] ident_o
);

    logic tx_l, modem_l, gpio_l, flow_l, pin_l;
    logic tx_clr, gpio_clr, spc_clr;
    logic [NUM_SRC-1:0] src;

    // a read acknowledges only the source whose code it returned
    assign tx_clr   = ident_rd_i && (ident_o == ID_TX);
    assign gpio_clr = ident_rd_i && (ident_o == ID_GPIO);
    assign spc_clr  = ident_rd_i && (ident_o == ID_FLOW);

    uart_irq_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_evt_i     (tx_evt_i),
        .modem_chg_i  (modem_chg_i),
        .gpio_chg_i   (gpio_chg_i),
        .xoff_det_i   (xoff_det_i),
        .spchar_det_i (spchar_det_i),
        .xon_det_i    (xon_det_i),
        .cts_n_i      (cts_n_i),
        .rts_n_i      (rts_n_i),
        .tx_clr_i     (tx_clr),
        .gpio_clr_i   (gpio_clr),
        .spc_clr_i    (spc_clr),
        .msr_rd_i     (msr_rd_i),
        .tx_o         (tx_l),
        .modem_o      (modem_l),
        .gpio_o       (gpio_l),
        .flow_o       (flow_l),
        .pin_o        (pin_l)
    );

    always_comb begin
        src            = '0;
        src[SRC_LINE]  = lsr_err_i;
        src[SRC_TOUT]  = rx_tout_i;
        src[SRC_RXD]   = rx_rdy_i;
        src[SRC_TX]    = tx_l;
        src[SRC_MODEM] = modem_l;
        src[SRC_GPIO]  = gpio_l;
        src[SRC_FLOW]  = flow_l;
        src[SRC_PIN]   = pin_l;
    end

    uart_irq_prio #(.N_SRC(NUM_SRC), .N_TYPE(NUM_TYPES)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .en_i    (en_i),
        .irq_n_o (irq_n_o),
        .ident_o (ident_o)
    );

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_l) && !$past(ident_rd_i && ident_o == ID_TX)) |-> tx_l); // R9

    AST_GPIO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ident_rd_i && ident_o == ID_GPIO && !gpio_chg_i) |-> !gpio_l); // R11

    AST_TX_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_evt_i) |-> tx_l); // R12

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] en = 7'h7F;
    logic lsr = 0, tout = 0, rdy = 0, txe = 0, mch = 0, gch = 0;
    logic xoff = 0, spc = 0, xon = 0, cts_n = 1, rts_n = 1, ird = 0, mrd = 0;
    logic       irq_n;
    logic [5:0] ident;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .en_i(en), .lsr_err_i(lsr), .rx_tout_i(tout),
        .rx_rdy_i(rdy), .tx_evt_i(txe), .modem_chg_i(mch), .gpio_chg_i(gch),
        .xoff_det_i(xoff), .spchar_det_i(spc), .xon_det_i(xon), .cts_n_i(cts_n),
        .rts_n_i(rts_n), .ident_rd_i(ird), .msr_rd_i(mrd), .irq_n_o(irq_n),
        .ident_o(ident)
    );

    task automatic chk(input string req, input logic [5:0] exp);
        checks++;
        if (ident !== exp || irq_n !== exp[0]) begin
            errors++;
            $display("FAIL %s: ident=%b irq_n=%b expected ident=%b irq_n=%b",
                     req, ident, irq_n, exp, exp[0]);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic id_read();
        ird = 1; step(); ird = 0;
    endtask

    task automatic ms_read();
        mrd = 1; step(); mrd = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset idle", 6'b000001);
    endtask

    task automatic t_codes();
        lsr = 1;  step(); chk("R3 line", 6'b000110); lsr = 0;
        tout = 1; step(); chk("R3 timeout", 6'b001100); tout = 0;
        rdy = 1;  step(); chk("R3 rxdata", 6'b000100); rdy = 0;
        txe = 1;  step(); txe = 0; chk("R3 tx", 6'b000010);
        id_read(); chk("R9 tx acked", 6'b000001);
        mch = 1;  step(); mch = 0; chk("R3 modem", 6'b000000);
        ms_read(); chk("R10 modem cleared", 6'b000001);
        gch = 1;  step(); gch = 0; chk("R3 gpio", 6'b001110);
        id_read(); chk("R11 gpio acked", 6'b000001);
    endtask

    task automatic t_priority();
        gch = 1; mch = 1; txe = 1; step(); gch = 0; mch = 0; txe = 0;
        lsr = 1; tout = 1; rdy = 1; step();
        chk("R4 line top", 6'b000110);
        lsr = 0; step(); chk("R4 timeout over rxdata / R12 level drop", 6'b001100);
        tout = 0; step(); chk("R4 rxdata", 6'b000100);
        id_read(); rdy = 0; step(); chk("R9 tx kept after other read", 6'b000010);
        id_read(); chk("R4 modem next", 6'b000000);
        id_read(); chk("R10 ident read leaves modem", 6'b000000);
        ms_read(); chk("R4 gpio last", 6'b001110);
        id_read(); chk("R11 idle again", 6'b000001);
    endtask

    task automatic t_enable();
        en = 7'h00; gch = 1; lsr = 1; step(); gch = 0;
        chk("R5 all masked", 6'b000001);
        en = 7'h10; step(); chk("R5 gpio unmasked shows held event", 6'b001110);
        en = 7'h11; step(); chk("R5 line unmasked", 6'b000110);
        lsr = 0; en = 7'h7F; id_read(); chk("R5 cleanup", 6'b000001);
    endtask

    task automatic t_flow();
        xoff = 1; step(); xoff = 0; chk("R6 stop char", 6'b010000);
        id_read(); chk("R6 read keeps stop char", 6'b010000);
        xon = 1; step(); xon = 0; chk("R6 start char clears", 6'b000001);
        spc = 1; step(); spc = 0; chk("R7 special char", 6'b010000);
        id_read(); chk("R7 read clears special", 6'b000001);
        spc = 1; xoff = 1; step(); spc = 0; xoff = 0;
        id_read(); chk("R7 read clears only special", 6'b010000);
        xon = 1; step(); xon = 0; chk("R6 both gone", 6'b000001);
    endtask

    task automatic t_pins();
        cts_n = 0; step(); step(); chk("R8 falling edge ignored", 6'b000001);
        cts_n = 1; step(); step(); chk("R8 cts rise", 6'b100000);
        ms_read(); chk("R10 pin latch cleared", 6'b000001);
        rts_n = 0; step(); step(); chk("R8 rts fall ignored", 6'b000001);
        rts_n = 1; step(); step(); chk("R8 rts rise", 6'b100000);
        id_read(); chk("R10 ident read leaves pin", 6'b100000);
        ms_read(); chk("R10 pin cleared again", 6'b000001);
    endtask

    task automatic t_set_wins();
        txe = 1; step(); txe = 0;
        txe = 1; ird = 1; step(); txe = 0; ird = 0;
        chk("R12 new event beats ack", 6'b000010);
        id_read(); chk("R12 then acked", 6'b000001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_codes();
        t_priority();
        t_enable();
        t_flow();
        t_pins();
        t_set_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule